// File: doc/BRIEF.md
# Serial Transmitter with Line Break Generation

This block serializes bytes onto a single transmit line. A byte written into a one-entry holding slot is moved into a frame engine at the next bit-rate tick. The engine sends a low start bit, the eight data bits least significant first, a parity bit (even or odd by a configuration input), a high stop bit, and then a programmable number of high guard bits. An external tick input marks every bit boundary. Each bit therefore lasts exactly one tick period, and a new frame can only begin on a tick.

Two command strobes control a line break. The break-begin command occupies the holding slot as a zero character. Its frames are all low, guard positions included, and they repeat back to back for as long as the break stays active. The break-end command lets the frame in progress finish, stops further break frames, and then holds the line high for twelve bit periods or for the guard length, whichever is longer. After that the engine resumes normal operation. Two status outputs tell software when the holding slot accepts a new byte and when the whole transmitter has gone quiet.

Top module: `uart_brk_tx`

## Requirements
- R1: After synchronous reset, `txd` is 1, `txrdy` is 1 and `txempty` is 1.
- R2: A normal frame is, in tick periods: one 0 start bit, data bits 0 to 7 in that order, one parity bit, one 1 stop bit, then `guard_len` bits of 1. A frame starts only on a `baud_tick` cycle.
- R3: With `par_odd`=0 the parity bit equals the XOR of the eight data bits. With `par_odd`=1 it is the inverse of that XOR.
- R4: A write (`wr_en`=1) is taken only while `txrdy`=1, and `txrdy` is 0 from the next cycle until the byte enters the frame engine. A write made while `txrdy`=0 is discarded and never appears on `txd`.
- R5: `brk_start` is accepted only while `txrdy`=1. Pulsed while `txrdy`=0, it produces no break, and the line returns to idle after the queued bytes.
- R6: An accepted `brk_start` drives `txrdy` and `txempty` to 0 from the next cycle. Each break frame holds `txd` at 0 for 11 + `guard_len` tick periods.
- R7: Break frames follow one another with no gap until `brk_stop` is pulsed. The total low time is a whole multiple of one break frame.
- R8: After `brk_stop`, the break frame in progress completes. `txd` then stays 1 for max(12, `guard_len`) tick periods before any new frame starts. `txempty` stays 0 until that period has ended.
- R9: A write issued in the same cycle as an accepted `brk_start`, or while a break is active, is discarded.
- R10: A `brk_start` accepted while a character is shifting does not cut that character short. The break begins right after its last guard bit.
- R11: `txempty` is 1 only when no frame or end-of-break period is in progress and nothing is held. It is 0 while any frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Write strobe for the holding slot |
| wr_data | input | 8 | Byte to transmit |
| brk_start | input | 1 | Command strobe: begin a line break |
| brk_stop | input | 1 | Command strobe: end the line break (wins if pulsed with `brk_start`) |
| par_odd | input | 1 | 0 selects even parity, 1 odd parity; latched per frame |
| guard_len | input | 8 | Number of guard bits after stop; 0 means none; latched per frame |
| txd | output | 1 | Serial output line, idle high |
| txrdy | output | 1 | Holding slot free for a write or break command |
| txempty | output | 1 | Transmitter fully idle |

## Verification
The embedded assertions check cycle-level rules on every clock: the line is high whenever the engine is idle, every frame starts with a low bit, an end-of-break period is entered only directly after a break frame, a break is armed only when the slot was free, a refused write leaves the held byte untouched, and an empty transmitter is always ready. The exact serial content can only be shown by the bench scenarios. Those cover every data byte under both parities, several guard lengths, how long a repeated break runs, the length of the high period after a break for short and long guard settings, refused break and data requests, and a break queued behind a character.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    localparam int DATA_W  = 8;
    localparam int GUARD_W = 8;
    localparam int END_MIN = 12;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_FRAME  = 2'd1,
        TX_BRKEND = 2'd2
    } tx_state_e;

    // Request offered by the holding slot to the frame engine.
    typedef struct packed {
        logic              valid;
        logic              brk;
        logic [DATA_W-1:0] data;
    } tx_req_t;

    // Line level at a given position of a frame (0 = start bit).
    function automatic logic frame_bit(
        input logic [DATA_W-1:0] d,
        input logic              odd,
        input logic              brk,
        input int                pos
    );
        logic [DATA_W-1:0] sh;
        if (brk) return 1'b0;
        if (pos == 0) return 1'b0;
        if (pos <= DATA_W) begin
            sh = d >> (pos - 1);
            return sh[0];
        end
        if (pos == DATA_W + 1) return (^d) ^ odd;
        return 1'b1;
    endfunction

endpackage

// File: rtl/uart_brk_hold.sv
module uart_brk_hold
    import uart_brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              brk_start,
    input  logic              brk_stop,
    input  logic              take,
    output tx_req_t           req,
    output logic              txrdy
);
    logic              full_q;
    logic              brk_q;
    logic [DATA_W-1:0] data_q;

    assign txrdy     = !full_q && !brk_q;
    assign req.valid = full_q || brk_q;
    assign req.brk   = brk_q;
    assign req.data  = brk_q ? '0 : data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            brk_q  <= 1'b0;
            data_q <= '0;
        end else begin
            // stop wins over a simultaneous start
            if (brk_stop)
                brk_q <= 1'b0;
            else if (brk_start && txrdy)
                brk_q <= 1'b1;

            if (take)
                full_q <= 1'b0;
            else if (wr_en && txrdy && !brk_start) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end
        end
    end

    // R4: a refused write leaves the held byte untouched
    a_r4_refused_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !txrdy) |=> $stable(data_q));

    // R5: a break is armed only when the slot was free
    a_r5_break_needs_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_q) |-> $past(txrdy));

endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift
    import uart_brk_pkg::*;
#(
    parameter int GW       = GUARD_W,
    parameter int END_BITS = END_MIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  tx_req_t       req,
    input  logic          par_odd,
    input  logic [GW-1:0] guard_len,
    output logic          take,
    output logic          txd,
    output logic          busy
);
    localparam int FRAME_BITS = DATA_W + 3;
    localparam int IDX_W      = $clog2(FRAME_BITS + (1 << GW) + END_BITS);

    tx_state_e         state;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] cur_data;
    logic              cur_brk;
    logic              cur_odd;
    logic [GW-1:0]     cur_guard;
    logic              frame_done;
    logic              enter_end;

    always_comb begin
        if (state == TX_BRKEND)
            last_idx = (IDX_W'(cur_guard) > IDX_W'(END_BITS))
                     ? IDX_W'(cur_guard) - IDX_W'(1)
                     : IDX_W'(END_BITS - 1);
        else
            last_idx = IDX_W'(FRAME_BITS - 1) + IDX_W'(cur_guard);
    end

    assign busy       = (state != TX_IDLE);
    assign frame_done = tick && busy && (idx == last_idx);
    assign enter_end  = (state == TX_FRAME) && cur_brk && !req.brk;
    assign take       = tick && req.valid &&
                        ((state == TX_IDLE) || (frame_done && !enter_end));

    always_comb begin
        case (state)
            TX_FRAME: txd = frame_bit(cur_data, cur_odd, cur_brk, int'(idx));
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            idx       <= '0;
            cur_data  <= '0;
            cur_brk   <= 1'b0;
            cur_odd   <= 1'b0;
            cur_guard <= '0;
        end else if (take) begin
            state     <= TX_FRAME;
            idx       <= '0;
            cur_data  <= req.data;
            cur_brk   <= req.brk;
            cur_odd   <= par_odd;
            cur_guard <= guard_len;
        end else if (frame_done) begin
            idx   <= '0;
            state <= enter_end ? TX_BRKEND : TX_IDLE;
        end else if (tick && busy) begin
            idx <= idx + IDX_W'(1);
        end
    end

    // R2: every frame opens with a low start level
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    // R2: idle line is high
    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R8: end-of-break period only directly after a break frame
    a_r8_end_after_break: assert property (@(posedge clk) disable iff (rst)
        (state == TX_BRKEND && $past(state) != TX_BRKEND)
            |-> ($past(state) == TX_FRAME && $past(cur_brk)));

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int GW       = GUARD_W,
    parameter int END_BITS = END_MIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              brk_start,
    input  logic              brk_stop,
    input  logic              par_odd,
    input  logic [GW-1:0]     guard_len,
    output logic              txd,
    output logic              txrdy,
    output logic              txempty
);
    tx_req_t req;
    logic    take;
    logic    busy;

    uart_brk_hold i_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .brk_start (brk_start),
        .brk_stop  (brk_stop),
        .take      (take),
        .req       (req),
        .txrdy     (txrdy)
    );

    uart_brk_shift #(
        .GW       (GW),
        .END_BITS (END_BITS)
    ) i_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .req       (req),
        .par_odd   (par_odd),
        .guard_len (guard_len),
        .take      (take),
        .txd       (txd),
        .busy      (busy)
    );

    assign txempty = !busy && !req.valid;

    // R11: a quiet transmitter always has a free slot
    a_r11_empty_ready: assert property (@(posedge clk) disable iff (rst)
        txempty |-> txrdy);

endmodule

// File: tb/test_uart_brk_tx.sv
module test_uart_brk_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cnt = 2'd0;
    logic       baud_tick;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       brk_start = 1'b0;
    logic       brk_stop = 1'b0;
    logic       par_odd = 1'b0;
    logic [7:0] guard_len = 8'd0;
    logic       txd, txrdy, txempty;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    logic rec_txd [0:1023];
    logic rec_emp [0:1023];
    int   nrec = 0;
    int   rp = 0;
    bit   rec_on = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 2'd1;
    assign baud_tick = (cnt == 2'd3);

    uart_brk_tx i_uart_brk_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .wr_en(wr_en), .wr_data(wr_data),
        .brk_start(brk_start), .brk_stop(brk_stop),
        .par_odd(par_odd), .guard_len(guard_len),
        .txd(txd), .txrdy(txrdy), .txempty(txempty)
    );

    // one sample per bit slot, in the middle of the slot
    always @(negedge clk) begin
        if (rec_on && cnt == 2'd1 && nrec < 1024) begin
            rec_txd[nrec] = txd;
            rec_emp[nrec] = txempty;
            nrec++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_rec();
        nrec = 0;
        rp = 0;
        rec_on = 1;
    endtask

    task automatic write_byte(input logic [7:0] d);
        int g = 0;
        while (!txrdy && g < 5000) begin
            @(negedge clk);
            g++;
        end
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        int g = 0;
        while (!txempty && g < 5000) begin
            @(negedge clk);
            g++;
        end
        clk_n(12);
    endtask

    function automatic int run_len(input int from, input logic v);
        int n = 0;
        while (from + n < nrec && rec_txd[from + n] === v) n++;
        return n;
    endfunction

    task automatic expect_frame(input logic [7:0] d, input logic odd, input int g,
                                input string tag);
        bit bad = 0;
        logic [7:0] got = 8'h00;
        logic e;
        while (rp < nrec && rec_txd[rp] === 1'b1) rp++;
        for (int k = 0; k < 11 + g; k++) begin
            if (k == 0) e = 1'b0;
            else if (k <= 8) e = d[k-1];
            else if (k == 9) e = (^d) ^ odd;
            else e = 1'b1;
            if (rp + k >= nrec) bad = 1;
            else begin
                if (rec_txd[rp + k] !== e) bad = 1;
                if (k >= 1 && k <= 8) got[k-1] = rec_txd[rp + k];
            end
        end
        check(!bad, tag, int'(got), int'(d));
        rp += 11 + g;
    endtask

    task automatic expect_idle_rest(input string tag);
        int r = run_len(rp, 1'b1);
        check(rp + r == nrec, tag, r, nrec - rp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int s, z, o;
        bit okb;
        clk_n(3);
        rst = 1'b0;
        clk_n(1);
        // R1 reset state
        check(txd === 1'b1, "R1 txd", txd, 1);
        check(txrdy === 1'b1, "R1 txrdy", txrdy, 1);
        check(txempty === 1'b1, "R1 txempty", txempty, 1);

        // R2 R3: every byte, both parities, no guard
        guard_len = 8'd0;
        for (int odd = 0; odd < 2; odd++) begin
            par_odd = odd[0];
            for (int ch = 0; ch < 8; ch++) begin
                start_rec();
                for (int i = 0; i < 32; i++) write_byte(8'(ch * 32 + i));
                wait_empty();
                rec_on = 0;
                for (int i = 0; i < 32; i++)
                    expect_frame(8'(ch * 32 + i), odd[0], 0, "R2 R3 sweep");
            end
        end

        // R2: guard lengths
        par_odd = 1'b0;
        for (int g = 0; g < 7; g++) begin
            guard_len = 8'(g);
            start_rec();
            for (int i = 0; i < 3; i++) write_byte(8'(8'h5A + g * 7 + i * 29));
            wait_empty();
            rec_on = 0;
            for (int i = 0; i < 3; i++)
                expect_frame(8'(8'h5A + g * 7 + i * 29), 1'b0, g, "R2 guard");
            expect_idle_rest("R2 idle after guard");
        end

        // R11: busy during frame, empty after
        write_byte(8'h33);
        clk_n(6);
        check(txempty === 1'b0, "R11 busy", txempty, 0);
        wait_empty();
        check(txempty === 1'b1, "R11 empty", txempty, 1);

        // R4 R5: refused write and refused break while slot full
        guard_len = 8'd1;
        start_rec();
        write_byte(8'h81);
        write_byte(8'h7E);
        check(txrdy === 1'b0, "R4 txrdy low while held", txrdy, 0);
        wr_data = 8'h3C;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(txrdy === 1'b0, "R5 precondition", txrdy, 0);
        brk_start = 1'b1;
        @(negedge clk);
        brk_start = 1'b0;
        wait_empty();
        rec_on = 0;
        expect_frame(8'h81, 1'b0, 1, "R4 first");
        expect_frame(8'h7E, 1'b0, 1, "R4 second");
        expect_idle_rest("R4 R5 nothing extra");

        // R10 R6 R7: break behind a shifting character
        guard_len = 8'd3;
        start_rec();
        write_byte(8'hC3);
        while (!txrdy) @(negedge clk);
        brk_start = 1'b1;
        @(negedge clk);
        brk_start = 1'b0;
        check(txrdy === 1'b0, "R6 txrdy", txrdy, 0);
        check(txempty === 1'b0, "R6 txempty", txempty, 0);
        clk_n(4 * 14 * 3);
        brk_stop = 1'b1;
        @(negedge clk);
        brk_stop = 1'b0;
        wait_empty();
        rec_on = 0;
        expect_frame(8'hC3, 1'b0, 3, "R10 char intact");
        z = run_len(rp, 1'b0);
        check(rec_txd[rp] === 1'b0, "R10 break right after guard", rec_txd[rp], 0);
        check(z % 14 == 0 && z >= 28, "R6 R7 break length", z, 42);

        // R8 R9: long guard, writes during break ignored
        guard_len = 8'd20;
        start_rec();
        clk_n(4);
        brk_start = 1'b1;
        wr_data = 8'h55;
        wr_en = 1'b1;
        @(negedge clk);
        brk_start = 1'b0;
        wr_data = 8'hA5;
        @(negedge clk);
        wr_en = 1'b0;
        clk_n(4 * 31 * 2);
        brk_stop = 1'b1;
        @(negedge clk);
        brk_stop = 1'b0;
        wait_empty();
        clk_n(4 * 24);
        rec_on = 0;
        s = run_len(0, 1'b1);
        z = run_len(s, 1'b0);
        o = run_len(s + z, 1'b1);
        check(z % 31 == 0 && z >= 62, "R7 repeated break frames", z, 62);
        check(s + z + o == nrec, "R9 no data frame", o, nrec - s - z);
        okb = 1;
        for (int k = s; k < s + z + 20; k++) if (rec_emp[k] !== 1'b0) okb = 0;
        check(okb, "R8 txempty low through end period", okb, 1);
        check(rec_emp[s + z + 20] === 1'b1, "R8 txempty after end period",
              rec_emp[s + z + 20], 1);

        // R8: short guard -> 12 high bits before next frame
        guard_len = 8'd2;
        start_rec();
        clk_n(4);
        brk_start = 1'b1;
        @(negedge clk);
        brk_start = 1'b0;
        clk_n(4 * 20);
        brk_stop = 1'b1;
        @(negedge clk);
        brk_stop = 1'b0;
        write_byte(8'h96);
        wait_empty();
        rec_on = 0;
        s = run_len(0, 1'b1);
        z = run_len(s, 1'b0);
        o = run_len(s + z, 1'b1);
        check(z % 13 == 0 && z >= 13, "R6 break frame length", z, 13);
        check(o == 12, "R8 end period 12 bits", o, 12);
        rp = s + z;
        expect_frame(8'h96, 1'b0, 2, "R8 frame after break");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule